// File: doc/BRIEF.md
# Periodic-Reference Trigger Synchronizer

This block lets several boards that share a common sample clock act on one shared trigger in the same sample-clock cycle, even though the trigger reaches each board at a different time. It sits in the sample-clock domain and counts out a periodic reference tick whose period is a programmable number of sample cycles. Every cooperating board uses the same period value, and it must be longer than the worst trigger propagation delay between boards. Each board brings its tick counter into the same phase in one of two ways. In reference mode the counter restarts on each rising edge of a slower shared reference clock, which must divide the sample clock by an integer. In host mode the counter restarts on a rising edge of a command line, and the reference clock is not used.

A raw trigger goes through a two-stage synchronizer and an edge detector and is then held pending. It is released as a one-cycle synchronized trigger only after the next tick. All boards tick in the same cycle, so all boards release in the same cycle. The block also reports how many sample cycles lay between the raw edge and the release. The interface is plain control and status: there is no data stream and no back-pressure.

Top module: `trig_align_sync`

## Requirements
- R1: With the period input `period` held steady and no align event, `tick` is high for exactly one cycle in every P cycles, where P is the effective period. `tick` is high in any cycle in which the internal counter is at zero.
- R2: The effective period is `period` when `period` is 2 or more, and 2 when `period` is 0 or 1.
- R3: When `host_mode` is 0, a rising edge on `ref_lvl` is an align event. `ref_lvl` is compared with its value at the previous edge and passes through no synchronizer stage. After an align event, `tick` is high in the cycle after the clock edge that sampled `ref_lvl` high. In this mode `align_req` has no effect.
- R4: When `host_mode` is 1, a rising edge on `align_req` is the align event and follows the same timing as R3. In this mode `ref_lvl` has no effect.
- R5: `aligned` rises at the edge that applies an align event. It falls at any edge where `period` differs from its value at the previous edge, and this clear takes priority over an align event at the same edge. Otherwise `aligned` holds its value.
- R6: A rising edge on `trig_raw` passes through two synchronizer flops and is then held pending. `trig_out` is a one-cycle pulse that appears in the cycle after a `tick` cycle in which the trigger was pending, and never at any other time.
- R7: Further trigger edges that arrive while a trigger is already pending merge into it, so only one `trig_out` pulse results.
- R8: At each release, `trig_delay` is loaded with the number of clock edges from the edge that first sampled `trig_raw` high up to the edge that raised `trig_out`. The value is at least 3. It holds between releases.
- R9: While `rst_n` is low, `trig_out` is 0, `aligned` is 0, `trig_delay` is 0 and `tick` is 1, because the counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_lvl | input | 1 | Level of the shared reference clock |
| trig_raw | input | 1 | Raw trigger line |
| period | input | CNT_W | Tick period in sample cycles |
| align_req | input | 1 | Host align command line |
| host_mode | input | 1 | 0: align on reference edges, 1: align on command |
| tick | output | 1 | Periodic reference tick |
| trig_out | output | 1 | Synchronized trigger pulse |
| aligned | output | 1 | Counter has been aligned since the last period change |
| trig_delay | output | DLY_W | Raw-to-release delay of the last trigger, in cycles |

## Verification
The hardest case to reach is a raw edge whose place in the tick cycle makes it land just before or just after a tick, since that changes the reported delay by a whole period. The stimulus first aligns the counter with a known command, so the tick phase is known in the bench. It then raises the trigger at each offset from 0 to 4 cycles after a tick, and checks both the release cycle and the delay value. The merge case follows a period change and realignment, with two trigger edges placed inside one long period.

// File: rtl/trsync_pkg.sv
package trsync_pkg;
  typedef enum logic {
    SRC_REFCLK = 1'b0,
    SRC_HOST   = 1'b1
  } align_src_e;

  // shortest tick period the counter will run at
  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/trsync_edge.sv
// Optional synchronizer chain followed by a rising-edge detector.
module trsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic cur;
  logic prev;

  generate
    if (STAGES == 0) begin : g_direct
      assign cur = din;
    end else begin : g_sync
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
        end else begin
          sr[0] <= din;
          for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign cur = sr[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  assign rise = cur & ~prev;
endmodule

// File: rtl/trsync_period.sv
// Tick counter with period clamp, alignment restart and aligned flag.
module trsync_period
  import trsync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             align_ev,
  output logic             tick,
  output logic             aligned
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;
  logic             chg;

  assign eff  = (period < MIN_P) ? MIN_P : period;
  assign last = eff - ONE;
  assign chg  = (period != per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (align_ev) begin
      cnt <= '0;
    end else if (cnt >= last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '0;
      aligned <= 1'b0;
    end else begin
      per_q <= period;
      if (chg)           aligned <= 1'b0;
      else if (align_ev) aligned <= 1'b1;
    end
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/trsync_release.sv
// Pending trigger latch, release on tick, delay measurement.
module trsync_release #(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             tick,
  output logic             trig_out,
  output logic [DLY_W-1:0] trig_delay
);
  localparam logic [DLY_W-1:0] START = DLY_W'(SYNC_STAGES);
  localparam logic [DLY_W-1:0] MAXV  = '1;
  localparam logic [DLY_W-1:0] ONE   = DLY_W'(1);

  logic             pend;
  logic             rel;
  logic [DLY_W-1:0] acc;

  assign rel = tick & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      trig_out   <= 1'b0;
      trig_delay <= '0;
      acc        <= '0;
    end else begin
      pend     <= (pend & ~rel) | rise;
      trig_out <= rel;
      if (rel) trig_delay <= (acc == MAXV) ? MAXV : acc + ONE;
      if (rise && (!pend || rel)) acc <= START;
      else if (pend && acc != MAXV) acc <= acc + ONE;
    end
  end
endmodule

// File: rtl/trig_align_sync.sv
module trig_align_sync
  import trsync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_lvl,
  input  logic             trig_raw,
  input  logic [CNT_W-1:0] period,
  input  logic             align_req,
  input  logic             host_mode,
  output logic             tick,
  output logic             trig_out,
  output logic             aligned,
  output logic [DLY_W-1:0] trig_delay
);
  align_src_e src;
  logic       ref_rise;
  logic       req_rise;
  logic       trig_rise;
  logic       align_ev;

  assign src = align_src_e'(host_mode);

  trsync_edge #(.STAGES(0)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .din(ref_lvl), .rise(ref_rise)
  );

  trsync_edge #(.STAGES(0)) u_req_edge (
    .clk(clk), .rst_n(rst_n), .din(align_req), .rise(req_rise)
  );

  trsync_edge #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst_n(rst_n), .din(trig_raw), .rise(trig_rise)
  );

  always_comb begin
    unique case (src)
      SRC_HOST:   align_ev = req_rise;
      default:    align_ev = ref_rise;
    endcase
  end

  trsync_period #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .period(period), .align_ev(align_ev),
    .tick(tick), .aligned(aligned)
  );

  trsync_release #(.SYNC_STAGES(SYNC_STAGES), .DLY_W(DLY_W)) u_release (
    .clk(clk), .rst_n(rst_n), .rise(trig_rise), .tick(tick),
    .trig_out(trig_out), .trig_delay(trig_delay)
  );
endmodule

// File: rtl/trsync_chk.sv
module trsync_chk #(
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             trig_out,
  input logic             aligned,
  input logic [CNT_W-1:0] period,
  input logic [DLY_W-1:0] trig_delay
);
  logic [1:0]       up;
  logic [CNT_W:0]   since_q;
  logic             seen_tick;
  logic             per_ok;
  logic [CNT_W-1:0] per_last;
  logic [CNT_W:0]   eff_chk;

  assign eff_chk = (period < CNT_W'(2)) ? (CNT_W+1)'(2) : {1'b0, period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up        <= '0;
      since_q   <= '0;
      seen_tick <= 1'b0;
      per_ok    <= 1'b0;
      per_last  <= '0;
    end else begin
      if (up != 2'd3) up <= up + 2'd1;
      per_last <= period;
      if (tick) begin
        since_q   <= '0;
        seen_tick <= 1'b1;
        per_ok    <= 1'b1;
      end else begin
        if (since_q != '1) since_q <= since_q + 1'b1;
        if (period != per_last) per_ok <= 1'b0;
      end
    end
  end

  // R1
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_tick && per_ok && !tick && period == per_last) |-> (since_q + 1'b1 < eff_chk));

  // R6
  rel_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up != 2'd0 && trig_out) |-> $past(tick));

  // R6
  pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  // R8
  dly_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (trig_delay >= DLY_W'(SYNC_STAGES + 1)));

  // R5
  per_chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up != 2'd0 && period != $past(period)) |=> !aligned);

  // R9
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!trig_out && !aligned && trig_delay == '0 && tick);
    end
  end
endmodule

bind trig_align_sync trsync_chk #(
  .CNT_W(CNT_W), .DLY_W(DLY_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .trig_out(trig_out),
  .aligned(aligned), .period(period), .trig_delay(trig_delay)
);

// File: tb/tb_trig_align_sync.sv
`timescale 1ns/1ps
module tb_trig_align_sync;
  localparam int CNT_W = 16;
  localparam int DLY_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ref_lvl;
  logic             trig_raw;
  logic [CNT_W-1:0] period;
  logic             align_req;
  logic             host_mode;
  logic             tick;
  logic             trig_out;
  logic             aligned;
  logic [DLY_W-1:0] trig_delay;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  trig_align_sync #(.CNT_W(CNT_W), .DLY_W(DLY_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .trig_raw(trig_raw),
    .period(period), .align_req(align_req), .host_mode(host_mode),
    .tick(tick), .trig_out(trig_out), .aligned(aligned), .trig_delay(trig_delay)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_aligned, m_out, m_dly, m_acc, m_pend, m_perq;
  int m_refp, m_reqp;
  int hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_aligned = 0; m_out = 0; m_dly = 0; m_acc = 0; m_pend = 0;
      m_perq = 0; m_refp = 0; m_reqp = 0;
      hist = '{0, 0, 0};
    end else begin
      int eff, ev, rel, rise;
      eff  = (period < 2) ? 2 : int'(period);
      ev   = host_mode ? (align_req && !m_reqp) : (ref_lvl && !m_refp);
      rel  = (m_cnt == 0) && m_pend;
      rise = hist[1] && !hist[2];
      if (period != m_perq) m_aligned = 0;
      else if (ev) m_aligned = 1;
      if (ev || m_cnt >= eff - 1) m_cnt = 0; else m_cnt++;
      m_out = rel;
      if (rel) m_dly = m_acc + 1;
      if (rise && (!m_pend || rel)) m_acc = 2;
      else if (m_pend) m_acc++;
      m_pend = (m_pend && !rel) || rise;
      void'(hist.pop_back());
      hist.push_front(int'(trig_raw));
      m_perq = period; m_refp = ref_lvl; m_reqp = align_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 tick vs model", tick, m_cnt == 0);
      chk("R6 trig_out vs model", trig_out, m_out);
      chk("R5 aligned vs model", aligned, m_aligned);
      chk("R8 trig_delay vs model", trig_delay, m_dly);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, tp, pulses;
    rst_n = 0; ref_lvl = 0; trig_raw = 0; period = 5; align_req = 0; host_mode = 1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 trig_out in reset", trig_out, 0);
    chk("R9 aligned in reset", aligned, 0);
    chk("R9 trig_delay in reset", trig_delay, 0);
    chk("R9 tick in reset", tick, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R4 host align
    align_req = 1;
    @(negedge clk); align_req = 0;
    chk("R4 tick after host align", tick, 1);
    chk("R5 aligned after host align", aligned, 1);
    gap(n); chk("R1 period 5 gap", n, 5);
    ref_lvl = 1;
    gap(n); chk("R4 ref ignored in host mode", n, 5);
    ref_lvl = 0;
    chk("R5 aligned holds", aligned, 1);

    // R6 R8 trigger at offsets 0..4 after a tick
    for (int off = 0; off < 5; off++) begin
      wait_tick();
      repeat (off) @(negedge clk);
      trig_raw = 1;
      n = 0; tp = tick;
      while (n < 50) begin
        @(negedge clk); n++;
        if (trig_out) break;
        tp = tick;
      end
      trig_raw = 0;
      chk("R6 release follows tick", tp, 1);
      chk("R8 delay equals edge count", trig_delay, n - 1);
      chk("R8 delay floor", (n - 1) >= 3, 1);
      repeat (8) @(negedge clk);
    end

    // R5 period change clears aligned, R7 merge
    period = 12;
    @(negedge clk);
    chk("R5 period change clears aligned", aligned, 0);
    align_req = 1; @(negedge clk); align_req = 0;
    chk("R5 realigned", aligned, 1);
    @(negedge clk);
    trig_raw = 1; @(negedge clk); trig_raw = 0;
    repeat (2) @(negedge clk);
    trig_raw = 1; @(negedge clk); trig_raw = 0;
    pulses = 0;
    repeat (14) begin @(negedge clk); if (trig_out) pulses++; end
    chk("R7 merged triggers give one pulse", pulses, 1);

    // R2 clamp
    period = 1;
    @(negedge clk);
    chk("R5 clear on change to 1", aligned, 0);
    wait_tick(); gap(n); chk("R2 period 1 clamps to 2", n, 2);
    period = 0;
    wait_tick(); wait_tick(); gap(n); chk("R2 period 0 clamps to 2", n, 2);

    // R3 reference mode
    host_mode = 0; period = 10;
    repeat (4) @(negedge clk);
    ref_lvl = 1;
    @(negedge clk);
    chk("R3 tick after ref edge", tick, 1);
    chk("R3 aligned after ref edge", aligned, 1);
    align_req = 1;
    gap(n); chk("R3 align_req ignored in ref mode", n, 10);
    align_req = 0;
    repeat (3) @(negedge clk);
    ref_lvl = 0; @(negedge clk);
    ref_lvl = 1; @(negedge clk);
    chk("R3 second ref edge realigns", tick, 1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule